// File: doc/BRIEF.md
# Address-Match Breakpoint Unit

This unit watches the instruction address bus of a small 8-bit processor and stops execution when a chosen 16-bit address comes up. Software loads the break address as two bytes and sets an enable bit. The unit compares each byte of the bus with its stored byte. When both bytes match and the enable bit is set, the unit sets a sticky flag and raises a request toward the system logic. It then waits for a legal instruction boundary and starts the break by supplying an interrupt opcode and a vector address, which the core loads.

While the break lasts, the unit holds a timer stopped. It also drives a qualifier that stops software from clearing peripheral status flags, unless the system has allowed clearing during a break. The break state ends when the core reports a return from interrupt. The vector moves to a different page while the part runs in monitor mode.

Top module: `brkpt_unit`

## Requirements
- R1: After reset, all three registers read 0x00, `brk_req`, `force_swi` and `tim_freeze` are 0, and `flag_clr_ok` is 1.
- R2: The registers are at byte addresses: break address high byte at 0xFE0C, low byte at 0xFE0D, and status/control at 0xFE0E with enable in bit 7 and the active flag in bit 6. Bits 5..0 of status read as 0. Reads of any other address return 0, and writes to any other address change nothing.
- R3: A match needs the enable bit set and both bytes of `iab` equal to the stored bytes. A difference in only the high byte, or only the low byte, causes no request.
- R4: `brk_req` is 1 in the cycle a qualified match is seen. It stays 1 while the break is pending.
- R5: When the match does not fall on a cycle with `last_cyc` set, the break waits. `force_swi` rises in the first later cycle with `insn_bound` set, and not before.
- R6: When the match comes in a cycle with `last_cyc` set, `force_swi` is 1 in that same cycle.
- R7: In a `force_swi` cycle, `ir_val` is 0x83. `vec_addr` is 0xFFFC, or 0xFEFC when `monitor_mode` is 1.
- R8: `tim_freeze` is 1 from the cycle after `force_swi` through the cycle in which `rti_done` is sampled, then returns to 0.
- R9: `flag_clr_ok` is 0 during the break state unless `clr_in_brk_en` is 1. Outside the break state it is 1.
- R10: The active flag sets on a qualified match. Writing 1 to bit 6 has no effect. Writing 0 to bit 6, or writing 0 to bit 7, clears the flag. Clearing the enable bit while a break is pending cancels that break.
- R11: One match produces exactly one `force_swi` pulse. Keeping the break address on `iab` while the break is pending or active starts no second break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 16 | Register access address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| iab | input | 16 | Instruction address bus |
| last_cyc | input | 1 | Current cycle is the last cycle of an instruction |
| insn_bound | input | 1 | Instruction boundary strobe |
| rti_done | input | 1 | Core completed return from interrupt |
| monitor_mode | input | 1 | Monitor mode selects the alternate vector |
| clr_in_brk_en | input | 1 | Allows status clearing during the break state |
| brk_req | output | 1 | Breakpoint request to system logic |
| force_swi | output | 1 | Load interrupt opcode and vector this cycle |
| ir_val | output | 8 | Opcode to force into the instruction register |
| vec_addr | output | 16 | Vector address for the program counter load |
| tim_freeze | output | 1 | Stops the timer counter |
| flag_clr_ok | output | 1 | Peripheral status clearing allowed |

## Verification
The bench first drives matches that are off by one byte in the high half and in the low half. A design that compares only one half would then break at the wrong address. It then holds the break address on the bus for several cycles before and after the boundary. A design that does not block repeat matches would inject a second interrupt opcode, and a design that ignores the last-cycle strobe would take the break one boundary late. The bench also clears the enable bit while a break is pending, to catch a leftover interrupt, and tries to set the flag by writing 1. Finally it checks the monitor-mode vector and the freeze window around the return strobe, to catch a timer that stays frozen or releases one cycle early.

// File: rtl/brk_pkg.sv
package brk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PEND = 2'd1,
    ST_BRK  = 2'd2
  } brk_state_e;
endpackage

// File: rtl/brk_regs.sv
module brk_regs #(
  parameter int              ADDR_W   = 16,
  parameter int              DATA_W   = 8,
  parameter logic [ADDR_W-1:0] REG_BASE = 16'hFE0C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              flag_set,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [ADDR_W-1:0] brk_addr,
  output logic              en,
  output logic              flag
);
  localparam int NB     = ADDR_W / DATA_W;
  localparam int NREG   = NB + 1;
  localparam int EN_BIT = DATA_W - 1;
  localparam int FL_BIT = DATA_W - 2;

  logic [ADDR_W-1:0] off;
  logic              sel_ok;
  logic              stat_wr;

  assign off     = reg_addr - REG_BASE;
  assign sel_ok  = (off < ADDR_W'(NREG));
  assign stat_wr = reg_wr && (off == ADDR_W'(NB));

  // Byte registers: the high byte sits at the lowest offset
  for (genvar g = 0; g < NB; g++) begin : g_byte
    localparam int OFS = NB - 1 - g;
    logic [DATA_W-1:0] byte_q;
    logic [DATA_W-1:0] byte_d;

    always_comb begin
      byte_d = byte_q;
      if (reg_wr && sel_ok && (off == ADDR_W'(OFS))) begin
        byte_d = reg_wdata;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        byte_q <= '0;
      end else begin
        byte_q <= byte_d;
      end
    end

    assign brk_addr[g*DATA_W +: DATA_W] = byte_q;
  end

  logic en_q, en_d;
  logic flag_q, flag_d;

  always_comb begin
    en_d   = en_q;
    flag_d = flag_q;
    if (stat_wr) begin
      en_d = reg_wdata[EN_BIT];
      if (!reg_wdata[FL_BIT] || !reg_wdata[EN_BIT]) begin
        flag_d = 1'b0;
      end
    end
    if (flag_set) begin
      flag_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      en_q   <= en_d;
      flag_q <= flag_d;
    end
  end

  assign en   = en_q;
  assign flag = flag_q;

  always_comb begin
    reg_rdata = '0;
    if (sel_ok) begin
      for (int i = 0; i < NB; i++) begin
        if (off == ADDR_W'(NB - 1 - i)) begin
          reg_rdata = brk_addr[i*DATA_W +: DATA_W];
        end
      end
      if (off == ADDR_W'(NB)) begin
        reg_rdata[EN_BIT] = en_q;
        reg_rdata[FL_BIT] = flag_q;
      end
    end
  end
endmodule

// File: rtl/brk_cmp.sv
module brk_cmp #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic [ADDR_W-1:0] iab,
  input  logic [ADDR_W-1:0] brk_addr,
  output logic              match
);
  localparam int NB = ADDR_W / DATA_W;

  logic [NB-1:0] byte_eq;

  // One byte-wide comparator per address byte
  for (genvar g = 0; g < NB; g++) begin : g_cmp
    assign byte_eq[g] = (iab[g*DATA_W +: DATA_W] == brk_addr[g*DATA_W +: DATA_W]);
  end

  assign match = &byte_eq;
endmodule

// File: rtl/brk_seq.sv
module brk_seq
  import brk_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter int                DATA_W   = 8,
  parameter logic [DATA_W-1:0] SWI_OPC  = 8'h83,
  parameter logic [ADDR_W-1:0] VEC_USER = 16'hFFFC,
  parameter logic [ADDR_W-1:0] VEC_MON  = 16'hFEFC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              match,
  input  logic              en,
  input  logic              last_cyc,
  input  logic              insn_bound,
  input  logic              rti_done,
  input  logic              monitor_mode,
  input  logic              clr_in_brk_en,
  output logic              hit,
  output logic              brk_req,
  output logic              force_swi,
  output logic [DATA_W-1:0] ir_val,
  output logic [ADDR_W-1:0] vec_addr,
  output logic              tim_freeze,
  output logic              flag_clr_ok
);
  brk_state_e st_q, st_d;
  logic take_now, take_pend;

  // A new match is only accepted when no break is pending or active
  assign hit       = (st_q == ST_IDLE) && en && match;
  assign take_now  = hit && last_cyc;
  assign take_pend = (st_q == ST_PEND) && en && insn_bound;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: begin
        if (take_now) begin
          st_d = ST_BRK;
        end else if (hit) begin
          st_d = ST_PEND;
        end
      end
      ST_PEND: begin
        if (!en) begin
          st_d = ST_IDLE;
        end else if (take_pend) begin
          st_d = ST_BRK;
        end
      end
      ST_BRK: begin
        if (rti_done) begin
          st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  assign brk_req     = hit || ((st_q == ST_PEND) && en);
  assign force_swi   = take_now || take_pend;
  assign ir_val      = force_swi ? SWI_OPC : '0;
  assign vec_addr    = monitor_mode ? VEC_MON : VEC_USER;
  assign tim_freeze  = (st_q == ST_BRK);
  assign flag_clr_ok = !tim_freeze || clr_in_brk_en;
endmodule

// File: rtl/brkpt_unit.sv
module brkpt_unit #(
  parameter int                ADDR_W   = 16,
  parameter int                DATA_W   = 8,
  parameter logic [ADDR_W-1:0] REG_BASE = 16'hFE0C,
  parameter logic [DATA_W-1:0] SWI_OPC  = 8'h83,
  parameter logic [ADDR_W-1:0] VEC_USER = 16'hFFFC,
  parameter logic [ADDR_W-1:0] VEC_MON  = 16'hFEFC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [ADDR_W-1:0] iab,
  input  logic              last_cyc,
  input  logic              insn_bound,
  input  logic              rti_done,
  input  logic              monitor_mode,
  input  logic              clr_in_brk_en,
  output logic              brk_req,
  output logic              force_swi,
  output logic [DATA_W-1:0] ir_val,
  output logic [ADDR_W-1:0] vec_addr,
  output logic              tim_freeze,
  output logic              flag_clr_ok
);
  logic [ADDR_W-1:0] brk_addr;
  logic              en;
  logic              flag;
  logic              match;
  logic              hit;

  brk_regs #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .REG_BASE(REG_BASE)
  ) regs_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_addr (reg_addr),
    .reg_wr   (reg_wr),
    .reg_wdata(reg_wdata),
    .flag_set (hit),
    .reg_rdata(reg_rdata),
    .brk_addr (brk_addr),
    .en       (en),
    .flag     (flag)
  );

  brk_cmp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) cmp_i (
    .iab     (iab),
    .brk_addr(brk_addr),
    .match   (match)
  );

  brk_seq #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .SWI_OPC (SWI_OPC),
    .VEC_USER(VEC_USER),
    .VEC_MON (VEC_MON)
  ) seq_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .match        (match),
    .en           (en),
    .last_cyc     (last_cyc),
    .insn_bound   (insn_bound),
    .rti_done     (rti_done),
    .monitor_mode (monitor_mode),
    .clr_in_brk_en(clr_in_brk_en),
    .hit          (hit),
    .brk_req      (brk_req),
    .force_swi    (force_swi),
    .ir_val       (ir_val),
    .vec_addr     (vec_addr),
    .tim_freeze   (tim_freeze),
    .flag_clr_ok  (flag_clr_ok)
  );
endmodule

// File: rtl/brkpt_unit_chk.sv
module brkpt_unit_chk #(
  parameter int                ADDR_W   = 16,
  parameter int                DATA_W   = 8,
  parameter logic [ADDR_W-1:0] REG_BASE = 16'hFE0C,
  parameter logic [DATA_W-1:0] SWI_OPC  = 8'h83
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              last_cyc,
  input logic              insn_bound,
  input logic              rti_done,
  input logic              clr_in_brk_en,
  input logic              brk_req,
  input logic              force_swi,
  input logic [DATA_W-1:0] ir_val,
  input logic              tim_freeze,
  input logic              flag_clr_ok
);
  localparam int NB = ADDR_W / DATA_W;

  AST_SWI_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    force_swi |-> brk_req); // R4

  AST_SWI_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    force_swi |-> (last_cyc || insn_bound)); // R5

  AST_SWI_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
    force_swi |-> (ir_val == SWI_OPC)); // R7

  AST_FREEZE_AFTER_SWI: assert property (@(posedge clk) disable iff (!rst_n)
    force_swi |=> tim_freeze); // R8

  AST_FREEZE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (tim_freeze && rti_done) |=> !tim_freeze); // R8

  AST_CLR_OUTSIDE_BRK: assert property (@(posedge clk) disable iff (!rst_n)
    (!tim_freeze || clr_in_brk_en) |-> flag_clr_ok); // R9

  AST_NO_SWI_IN_BRK: assert property (@(posedge clk) disable iff (!rst_n)
    tim_freeze |-> !force_swi); // R11

  AST_UNIMP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == REG_BASE + ADDR_W'(NB)) |-> (reg_rdata[DATA_W-3:0] == '0)); // R2
endmodule

bind brkpt_unit brkpt_unit_chk #(
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .REG_BASE(REG_BASE),
  .SWI_OPC (SWI_OPC)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_addr     (reg_addr),
  .reg_rdata    (reg_rdata),
  .last_cyc     (last_cyc),
  .insn_bound   (insn_bound),
  .rti_done     (rti_done),
  .clr_in_brk_en(clr_in_brk_en),
  .brk_req      (brk_req),
  .force_swi    (force_swi),
  .ir_val       (ir_val),
  .tim_freeze   (tim_freeze),
  .flag_clr_ok  (flag_clr_ok)
);

// File: tb/brkpt_unit_tb_top.sv
module brkpt_unit_tb_top;
  localparam logic [15:0] A_HI  = 16'hFE0C;
  localparam logic [15:0] A_LO  = 16'hFE0D;
  localparam logic [15:0] A_ST  = 16'hFE0E;
  localparam logic [15:0] BADDR = 16'h1234;
  localparam logic [15:0] AWAY  = 16'h2000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] reg_addr;
  logic        reg_wr;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata;
  logic [15:0] iab;
  logic        last_cyc, insn_bound, rti_done, monitor_mode, clr_in_brk_en;
  logic        brk_req, force_swi, tim_freeze, flag_clr_ok;
  logic [7:0]  ir_val;
  logic [15:0] vec_addr;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  brkpt_unit dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .iab(iab),
    .last_cyc(last_cyc), .insn_bound(insn_bound), .rti_done(rti_done),
    .monitor_mode(monitor_mode), .clr_in_brk_en(clr_in_brk_en),
    .brk_req(brk_req), .force_swi(force_swi), .ir_val(ir_val),
    .vec_addr(vec_addr), .tim_freeze(tim_freeze), .flag_clr_ok(flag_clr_ok)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr  = a;
    reg_wdata = d;
    reg_wr    = 1'b1;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [15:0] a, input logic [7:0] exp);
    reg_addr = a;
    #1;
    chk(tag, {24'd0, reg_rdata}, {24'd0, exp});
  endtask

  task automatic t_reset;
    @(negedge clk);
    #1;
    rd_chk("R1 hi reset", A_HI, 8'h00);
    rd_chk("R1 lo reset", A_LO, 8'h00);
    rd_chk("R1 status reset", A_ST, 8'h00);
    chk("R1 brk_req", {31'd0, brk_req}, 0);
    chk("R1 force_swi", {31'd0, force_swi}, 0);
    chk("R1 tim_freeze", {31'd0, tim_freeze}, 0);
    chk("R1 flag_clr_ok", {31'd0, flag_clr_ok}, 1);
  endtask

  task automatic t_regs;
    wr(A_HI, 8'h12);
    wr(A_LO, 8'h34);
    wr(A_ST, 8'hFF);
    rd_chk("R2 hi", A_HI, 8'h12);
    rd_chk("R2 lo", A_LO, 8'h34);
    rd_chk("R2 R10 status bit6 write 1 ignored", A_ST, 8'h80);
    wr(16'hFE0F, 8'hAA);
    wr(16'hFE0B, 8'h55);
    rd_chk("R2 unmapped read", 16'hFE0F, 8'h00);
    rd_chk("R2 hi unchanged", A_HI, 8'h12);
    rd_chk("R2 lo unchanged", A_LO, 8'h34);
    rd_chk("R2 status unchanged", A_ST, 8'h80);
  endtask

  task automatic t_partial;
    @(negedge clk);
    iab = 16'h1235; last_cyc = 1'b1;
    #1;
    chk("R3 low byte differs req", {31'd0, brk_req}, 0);
    chk("R3 low byte differs swi", {31'd0, force_swi}, 0);
    iab = 16'h1334;
    #1;
    chk("R3 high byte differs req", {31'd0, brk_req}, 0);
    chk("R3 high byte differs swi", {31'd0, force_swi}, 0);
    @(negedge clk);
    iab = AWAY; last_cyc = 1'b0;
    wr(A_ST, 8'h00);
    @(negedge clk);
    iab = BADDR; last_cyc = 1'b1;
    #1;
    chk("R3 disabled req", {31'd0, brk_req}, 0);
    chk("R3 disabled swi", {31'd0, force_swi}, 0);
    @(negedge clk);
    iab = AWAY; last_cyc = 1'b0;
    rd_chk("R10 no flag when disabled", A_ST, 8'h00);
    wr(A_ST, 8'h80);
  endtask

  task automatic t_deferred;
    monitor_mode = 1'b0;
    @(negedge clk);
    iab = BADDR; last_cyc = 1'b0;
    #1;
    chk("R4 req on match", {31'd0, brk_req}, 1);
    chk("R5 no swi mid instruction", {31'd0, force_swi}, 0);
    @(negedge clk);
    iab = AWAY; reg_addr = A_ST;
    #1;
    chk("R4 req held pending", {31'd0, brk_req}, 1);
    chk("R5 no swi before boundary", {31'd0, force_swi}, 0);
    chk("R10 flag set", {24'd0, reg_rdata}, 32'hC0);
    @(negedge clk);
    insn_bound = 1'b1;
    #1;
    chk("R5 swi at boundary", {31'd0, force_swi}, 1);
    chk("R7 opcode", {24'd0, ir_val}, 32'h83);
    chk("R7 user vector", {16'd0, vec_addr}, 32'hFFFC);
    @(negedge clk);
    insn_bound = 1'b0; iab = BADDR; last_cyc = 1'b1;
    #1;
    chk("R8 freeze in break", {31'd0, tim_freeze}, 1);
    chk("R11 no retrigger in break", {31'd0, force_swi}, 0);
    chk("R11 no req in break", {31'd0, brk_req}, 0);
    chk("R9 clear blocked", {31'd0, flag_clr_ok}, 0);
    @(negedge clk);
    iab = AWAY; last_cyc = 1'b0; rti_done = 1'b1;
    #1;
    chk("R8 freeze through rti cycle", {31'd0, tim_freeze}, 1);
    @(negedge clk);
    rti_done = 1'b0;
    #1;
    chk("R8 freeze released", {31'd0, tim_freeze}, 0);
    chk("R9 clear allowed after break", {31'd0, flag_clr_ok}, 1);
    rd_chk("R10 flag sticky after break", A_ST, 8'hC0);
    wr(A_ST, 8'h80);
    rd_chk("R10 flag cleared by write 0", A_ST, 8'h80);
  endtask

  task automatic t_immediate;
    monitor_mode = 1'b1;
    @(negedge clk);
    iab = BADDR; last_cyc = 1'b1;
    #1;
    chk("R6 swi same cycle", {31'd0, force_swi}, 1);
    chk("R7 monitor vector", {16'd0, vec_addr}, 32'hFEFC);
    @(negedge clk);
    iab = AWAY; last_cyc = 1'b0; clr_in_brk_en = 1'b1;
    #1;
    chk("R8 freeze after immediate", {31'd0, tim_freeze}, 1);
    chk("R9 clear permitted by control", {31'd0, flag_clr_ok}, 1);
    clr_in_brk_en = 1'b0;
    #1;
    chk("R9 clear blocked again", {31'd0, flag_clr_ok}, 0);
    @(negedge clk);
    rti_done = 1'b1;
    @(negedge clk);
    rti_done = 1'b0; monitor_mode = 1'b0;
    wr(A_ST, 8'h80);
  endtask

  task automatic t_cancel;
    @(negedge clk);
    iab = BADDR; last_cyc = 1'b0;
    @(negedge clk);
    iab = AWAY;
    wr(A_ST, 8'h00);
    insn_bound = 1'b1;
    #1;
    chk("R10 cancelled no swi", {31'd0, force_swi}, 0);
    chk("R10 cancelled no req", {31'd0, brk_req}, 0);
    rd_chk("R10 flag cleared by disable", A_ST, 8'h00);
    @(negedge clk);
    insn_bound = 1'b0;
    #1;
    chk("R10 still no break", {31'd0, tim_freeze}, 0);
    wr(A_ST, 8'h80);
  endtask

  task automatic t_hold;
    int pulses = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      iab = BADDR;
      insn_bound = (i == 3);
      #1;
      if (force_swi) pulses++;
    end
    @(negedge clk);
    iab = AWAY; insn_bound = 1'b0;
    chk("R11 single break from held address", pulses, 1);
    rti_done = 1'b1;
    @(negedge clk);
    rti_done = 1'b0;
    wr(A_ST, 8'h80);
  endtask

  initial begin
    #(200000 * 10);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    reg_addr = '0; reg_wr = 1'b0; reg_wdata = '0;
    iab = AWAY; last_cyc = 1'b0; insn_bound = 1'b0; rti_done = 1'b0;
    monitor_mode = 1'b0; clr_in_brk_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_partial();
    t_deferred();
    t_immediate();
    t_cancel();
    t_hold();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule